// File: doc/BRIEF.md
# PLCP Trailer Nibble Stuffing Sequencer

This block paces the transmit PLCP frames of a DS3 ATM path and decides, frame by frame, how long the trailer after each frame is. Every frame has a body of `BODY_NIB` nibble slots, one slot per clock. A trailer of 13 or 14 nibbles follows the body. Frames are grouped into repeating cycles of three. The first frame of a cycle always takes the short trailer and the second always takes the long one. The third frame is the stuff opportunity, and its trailer length is decided on the fly.

The stuff decision has two sources. The external stuff control decides it in pin mode. An asynchronous 8 kHz reference decides it in reference mode. Reference mode is chosen when the timing reference select equals binary 01. In that mode each frame starts on a rising edge of the reference, and the third frame is lengthened only when its trailer begins before the next reference edge has arrived. In clear-channel mode both asynchronous inputs are forced inactive and no stuffing takes place. Downstream framing logic uses the frame start strobe, the per-nibble trailer strobe, the reported trailer length and the cycle phase to insert the trailer nibbles.

Top module: `plcp_stuff_seq`

## Requirements
- R1: `cycle_phase` is 0 for the first frame after reset and advances 0→1→2→0 only on a `frame_start`. While reset is asserted, `frame_start` and `trailer_nib` stay 0 and `cycle_phase` is 0.
- R2: A frame in phase 0 always gets a trailer length of 13.
- R3: A frame in phase 1 always gets a trailer length of 14.
- R4: In pin mode (`tref_sel` not 01, `clear_mode` 0), a phase 2 frame takes the synchronized `stuff_in` value sampled at its first trailer nibble. A value of 0 gives 13 and a value of 1 gives 14.
- R5: Changing `stuff_in` after the phase 2 trailer has started does not change that trailer's length or pulse count.
- R6: In reference mode (`tref_sel` = 01, `clear_mode` 0), a frame starts only after a synchronized rising edge of `ref_8k_in`. With no reference edges there are no frame starts. With a reference period longer than a frame, frame starts are spaced exactly one reference period apart.
- R7: In reference mode, a phase 2 frame gets 14 when no reference edge has occurred between its start and its first trailer nibble. Otherwise it gets 13.
- R8: In clear-channel mode the reference is ignored, frames run back to back, and a phase 2 frame always gets 13 whatever `stuff_in` is.
- R9: `trailer_nib` pulses exactly `trailer_len` times per frame, `trailer_len` is 13 or 14 and stays stable through the trailer, and `trailer_nib` is never high together with `frame_start`.
- R10: Outside reference mode, frames run back to back, and consecutive frame starts are `BODY_NIB` + trailer length cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nibble-rate line clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_8k_in | input | 1 | Asynchronous 8 kHz frame reference |
| stuff_in | input | 1 | Asynchronous external stuff control (1 = stuff) |
| tref_sel | input | 2 | Timing reference select; 01 selects reference mode |
| clear_mode | input | 1 | Clear-channel mode; disables stuffing and reference |
| frame_start | output | 1 | One-cycle strobe on the first body nibble of a frame |
| trailer_len | output | 4 | Trailer length of the current frame, 13 or 14 |
| trailer_nib | output | 1 | High in each trailer nibble slot |
| cycle_phase | output | 2 | Position of the current frame in the three-frame cycle |

## Verification
The bench builds the block with `BODY_NIB` = 20 and two synchronizer stages. A frame then lasts 33 or 34 cycles, so each scenario covers every cycle phase many times. Reference periods of 15 and 60 cycles fall on either side of the body length, which reaches both outcomes of the reference-mode stuff decision and the idle wait between frames. The short frames also make room for a stuff control toggle in the middle of a trailer and for a reference held low.

// File: rtl/plcp_stuff_pkg.sv
package plcp_stuff_pkg;

    localparam logic [3:0] TRL_SHORT = 4'd13;
    localparam logic [3:0] TRL_LONG  = 4'd14;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BODY  = 2'd1,
        ST_TRAIL = 2'd2
    } seq_state_t;

    function automatic logic [1:0] next_phase(input logic [1:0] ph);
        return (ph == 2'd2) ? 2'd0 : ph + 2'd1;
    endfunction

    // Trailer length for a frame, decided at its first trailer nibble.
    function automatic logic [3:0] pick_len(
        input logic [1:0] ph,
        input logic       ref_mode,
        input logic       clr,
        input logic       stuff,
        input logic       edge_seen
    );
        if (ph == 2'd0) return TRL_SHORT;
        if (ph == 2'd1) return TRL_LONG;
        if (clr)        return TRL_SHORT;
        if (ref_mode)   return edge_seen ? TRL_SHORT : TRL_LONG;
        return stuff ? TRL_LONG : TRL_SHORT;
    endfunction

endpackage

// File: rtl/plcp_sync.sv
module plcp_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[i] <= '0;
            else     stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/plcp_rise_det.sv
module plcp_rise_det (
    input  logic clk,
    input  logic rst,
    input  logic sig,
    output logic rise
);
    logic sig_d;

    always_ff @(posedge clk) begin
        if (rst) sig_d <= 1'b0;
        else     sig_d <= sig;
    end

    assign rise = sig & ~sig_d;
endmodule

// File: rtl/plcp_frame_seq.sv
module plcp_frame_seq
    import plcp_stuff_pkg::*;
#(
    parameter int BODY_NIB = 1360,
    parameter int CNT_W    = 11
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ref_mode,
    input  logic       clear_mode,
    input  logic       ref_edge,
    input  logic       stuff_s,
    output logic       frame_start,
    output logic       trailer_nib,
    output logic [3:0] trailer_len,
    output logic [1:0] phase
);
    localparam logic [CNT_W-1:0] BODY_LAST = CNT_W'(BODY_NIB - 1);

    seq_state_t       st;
    logic [CNT_W-1:0] cnt;
    logic             pend;
    logic             started;
    logic             go;
    logic             last_body;
    logic             last_trl;
    logic             consume;
    logic             edge_seen;

    assign go        = ref_mode ? (ref_edge | pend) : 1'b1;
    assign last_body = (st == ST_BODY) && (cnt == BODY_LAST);
    assign last_trl  = (st == ST_TRAIL) && (cnt == CNT_W'(trailer_len - 4'd1));
    assign consume   = go && ((st == ST_IDLE) || last_trl);
    assign edge_seen = pend | ref_edge;

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            cnt         <= '0;
            pend        <= 1'b0;
            started     <= 1'b0;
            phase       <= 2'd0;
            trailer_len <= TRL_SHORT;
        end else begin
            if (consume)       pend <= 1'b0;
            else if (ref_edge) pend <= 1'b1;

            case (st)
                ST_IDLE: begin
                    if (go) begin
                        st      <= ST_BODY;
                        cnt     <= '0;
                        started <= 1'b1;
                        if (started) phase <= next_phase(phase);
                    end
                end
                ST_BODY: begin
                    if (last_body) begin
                        st          <= ST_TRAIL;
                        cnt         <= '0;
                        trailer_len <= pick_len(phase, ref_mode, clear_mode,
                                                stuff_s, edge_seen);
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_TRAIL: begin
                    if (last_trl) begin
                        cnt <= '0;
                        if (go) begin
                            st    <= ST_BODY;
                            phase <= next_phase(phase);
                        end else begin
                            st <= ST_IDLE;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign frame_start = (st == ST_BODY) && (cnt == '0);
    assign trailer_nib = (st == ST_TRAIL);
endmodule

// File: rtl/plcp_stuff_seq.sv
module plcp_stuff_seq #(
    parameter int BODY_NIB    = 1360,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ref_8k_in,
    input  logic       stuff_in,
    input  logic [1:0] tref_sel,
    input  logic       clear_mode,
    output logic       frame_start,
    output logic [3:0] trailer_len,
    output logic       trailer_nib,
    output logic [1:0] cycle_phase
);
    localparam int CNT_W = ($clog2(BODY_NIB) > 4) ? $clog2(BODY_NIB) : 4;

    logic [1:0] async_in;
    logic [1:0] sync_out;
    logic       ref_edge;
    logic       ref_mode;

    // Asynchronous inputs are held inactive in clear-channel mode.
    assign async_in = {stuff_in & ~clear_mode, ref_8k_in & ~clear_mode};
    assign ref_mode = (tref_sel == 2'b01) && !clear_mode;

    plcp_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (async_in),
        .q   (sync_out)
    );

    plcp_rise_det u_edge (
        .clk  (clk),
        .rst  (rst),
        .sig  (sync_out[0]),
        .rise (ref_edge)
    );

    plcp_frame_seq #(.BODY_NIB(BODY_NIB), .CNT_W(CNT_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .ref_mode    (ref_mode),
        .clear_mode  (clear_mode),
        .ref_edge    (ref_edge),
        .stuff_s     (sync_out[1]),
        .frame_start (frame_start),
        .trailer_nib (trailer_nib),
        .trailer_len (trailer_len),
        .phase       (cycle_phase)
    );
endmodule

// File: rtl/plcp_stuff_chk.sv
module plcp_stuff_chk (
    input logic       clk,
    input logic       rst,
    input logic       clear_mode,
    input logic       frame_start,
    input logic [3:0] trailer_len,
    input logic       trailer_nib,
    input logic [1:0] cycle_phase
);
    a_r1_phase_step: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && cycle_phase != $past(cycle_phase)) |->
        (frame_start && cycle_phase == (($past(cycle_phase) == 2'd2) ? 2'd0 : $past(cycle_phase) + 2'd1)));

    a_r1_phase_range: assert property (@(posedge clk) disable iff (rst)
        cycle_phase != 2'd3);

    a_r2_first_short: assert property (@(posedge clk) disable iff (rst)
        (trailer_nib && cycle_phase == 2'd0) |-> trailer_len == 4'd13);

    a_r3_second_long: assert property (@(posedge clk) disable iff (rst)
        (trailer_nib && cycle_phase == 2'd1) |-> trailer_len == 4'd14);

    a_r8_clear_no_stuff: assert property (@(posedge clk) disable iff (rst)
        (clear_mode && trailer_nib && cycle_phase == 2'd2) |-> trailer_len == 4'd13);

    a_r9_len_legal: assert property (@(posedge clk) disable iff (rst)
        trailer_nib |-> (trailer_len == 4'd13 || trailer_len == 4'd14));

    a_r9_len_stable: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && trailer_nib && $past(trailer_nib)) |-> $stable(trailer_len));

    a_r9_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(frame_start && trailer_nib));
endmodule

bind plcp_stuff_seq plcp_stuff_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .clear_mode  (clear_mode),
    .frame_start (frame_start),
    .trailer_len (trailer_len),
    .trailer_nib (trailer_nib),
    .cycle_phase (cycle_phase)
);

// File: tb/sim_plcp_stuff_seq.sv
`timescale 1ns/1ps
module sim_plcp_stuff_seq;
    localparam int BODY = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_8k_in = 1'b0;
    logic       stuff_in = 1'b0;
    logic [1:0] tref_sel = 2'b00;
    logic       clear_mode = 1'b0;
    logic       frame_start;
    logic [3:0] trailer_len;
    logic       trailer_nib;
    logic [1:0] cycle_phase;

    int total = 0;
    int fails = 0;
    bit done = 0;

    // scenario controls
    int    ref_period = 0;
    bit    mon_en = 0;
    int    exp3 = 13;
    string tag3 = "R4";
    int    exp_gap = 0;     // -1: BODY+len, >0: fixed, 0: none
    string gap_tag = "R10";
    bit    toggle_en = 0;
    int    starts_seen = 0;

    always #2 clk = ~clk;

    plcp_stuff_seq #(.BODY_NIB(BODY), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst(rst), .ref_8k_in(ref_8k_in), .stuff_in(stuff_in),
        .tref_sel(tref_sel), .clear_mode(clear_mode),
        .frame_start(frame_start), .trailer_len(trailer_len),
        .trailer_nib(trailer_nib), .cycle_phase(cycle_phase)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // reference generator
    initial begin
        int rc = 0;
        forever begin
            @(negedge clk);
            if (ref_period > 0) begin
                rc = (rc + 1 >= ref_period) ? 0 : rc + 1;
                ref_8k_in = (rc < 3);
            end else begin
                rc = 0;
                ref_8k_in = 1'b0;
            end
        end
    end

    // mid-trailer stuff toggle (R5)
    initial begin
        forever begin
            @(negedge clk);
            if (toggle_en && trailer_nib && cycle_phase == 2'd2) begin
                repeat (3) @(negedge clk);
                stuff_in = ~stuff_in;
                while (trailer_nib) @(negedge clk);
                stuff_in = ~stuff_in;
            end
        end
    end

    // frame monitor
    initial begin
        bit   have_prev = 0;
        int   cyc = 0;
        int   start_cyc = 0;
        int   nibs = 0;
        int   rep_len = 0;
        bit   stable_ok = 1;
        logic [1:0] prev_ph = 0;
        forever begin
            @(negedge clk);
            cyc++;
            if (!mon_en) begin
                have_prev = 0;
            end else begin
                if (trailer_nib) begin
                    if (nibs == 0) rep_len = trailer_len;
                    else if (trailer_len != rep_len) stable_ok = 0;
                    nibs++;
                end
                if (frame_start) begin
                    starts_seen++;
                    if (have_prev) begin
                        int el;
                        string lt;
                        el = (prev_ph == 0) ? 13 : (prev_ph == 1) ? 14 : exp3;
                        lt = (prev_ph == 0) ? "R2" : (prev_ph == 1) ? "R3" : tag3;
                        chk(nibs == rep_len && stable_ok, "R9 pulse count", nibs, rep_len);
                        chk(rep_len == el, lt, rep_len, el);
                        chk(cycle_phase == ((prev_ph == 2) ? 2'd0 : prev_ph + 2'd1),
                            "R1 phase step", cycle_phase, (prev_ph + 1) % 3);
                        if (exp_gap == -1)
                            chk(cyc - start_cyc == BODY + rep_len, gap_tag,
                                cyc - start_cyc, BODY + rep_len);
                        else if (exp_gap > 0)
                            chk(cyc - start_cyc == exp_gap, gap_tag,
                                cyc - start_cyc, exp_gap);
                    end else begin
                        chk(cycle_phase == 2'd0, "R1 first phase", cycle_phase, 0);
                    end
                    have_prev = 1;
                    prev_ph   = cycle_phase;
                    start_cyc = cyc;
                    nibs      = 0;
                    stable_ok = 1;
                end
            end
        end
    end

    task automatic run_scn(input logic [1:0] ts, input bit clr, input bit st,
                           input int rp, input int cycles);
        mon_en = 0;
        @(negedge clk);
        rst = 1'b1;
        tref_sel = ts;
        clear_mode = clr;
        stuff_in = st;
        ref_period = rp;
        repeat (6) @(negedge clk);
        chk(frame_start == 1'b0, "R1 reset frame_start", frame_start, 0);
        chk(trailer_nib == 1'b0, "R1 reset trailer_nib", trailer_nib, 0);
        chk(cycle_phase == 2'd0, "R1 reset phase", cycle_phase, 0);
        rst = 1'b0;
        starts_seen = 0;
        mon_en = 1;
        repeat (cycles) @(negedge clk);
        mon_en = 0;
    endtask

    initial begin
        // R4: pin mode, no stuff
        exp3 = 13; tag3 = "R4"; exp_gap = -1; gap_tag = "R10";
        run_scn(2'b00, 0, 0, 0, 420);
        // R4: pin mode, stuff
        exp3 = 14; tag3 = "R4";
        run_scn(2'b10, 0, 1, 0, 420);
        // R5: toggles during the phase 2 trailer
        toggle_en = 1;
        exp3 = 14; tag3 = "R5";
        run_scn(2'b11, 0, 1, 0, 420);
        exp3 = 13; tag3 = "R5";
        run_scn(2'b00, 0, 0, 0, 420);
        toggle_en = 0;
        // R6/R7: slow reference, idle between frames, third frame stuffed
        exp3 = 14; tag3 = "R7"; exp_gap = 60; gap_tag = "R6";
        run_scn(2'b01, 0, 0, 60, 1000);
        // R7: fast reference, edge inside every body, no stuff
        exp3 = 13; tag3 = "R7"; exp_gap = 0;
        run_scn(2'b01, 0, 1, 15, 700);
        // R6: no reference edges, no frames
        run_scn(2'b01, 0, 1, 0, 300);
        chk(starts_seen == 0, "R6 no ref no frame", starts_seen, 0);
        // R8: clear-channel mode ignores reference and stuff control
        exp3 = 13; tag3 = "R8"; exp_gap = -1; gap_tag = "R8 back to back";
        run_scn(2'b01, 1, 1, 15, 420);
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule